// File: doc/BRIEF.md
# In-Order Speculative Commit Sequencer

Several processors run speculative transaction blocks at the same time. Each block may write to memory only once every earlier block in program order has done so. This sequencer holds a wrapping sequence counter, the head, which names the one block that may commit next. Each processor reports four things:

- whether it currently holds a block,
- that block's sequence number,
- whether the block has finished executing,
- whether the block lies on a branch that was not taken.

When the head block is finished, the sequencer sends its processor a one-cycle commit grant. It then waits for that processor to answer. A commit-done acknowledge means the write-back sweep has completed, and the head advances. A retry answer means a prediction failed and the block must run again, so the head stays where it is.

If the block at the head is marked as lying on an untaken branch, the sequencer retires it without a grant. It then moves on to the next block. When no processor holds the head block, the sequencer raises nothing and waits.

Top module: `commit_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it, the grant vector is all zero and the head is 0.
- R2: When the sequencer is not waiting and a processor has its valid bit high and its id equal to the head, with done high and abandon low, that processor's grant bit goes high after the next clock edge for exactly one cycle. Grant bit i belongs to processor i.
- R3: At most one grant bit is ever high. If several processors hold the head id, the lowest-numbered one is chosen.
- R4: After a grant the head holds and no new grant is issued until the granted processor returns an acknowledge or a retry. Acknowledge or retry bits from other processors have no effect.
- R5: An acknowledge from the granted processor advances the head by one at that edge. If the next block is already finished, its grant follows at the very next edge.
- R6: A retry from the granted processor keeps the head unchanged and resumes scanning. If the block still reports done, it is granted again one edge later. An acknowledge wins over a retry that arrives at the same time.
- R7: A matching processor whose abandon bit is high, outside a wait, makes the head advance by one without any grant. This happens even if done is also high, and at most one block is retired per cycle.
- R8: When no valid processor holds the head id, the head holds and no grant is raised.
- R9: The head wraps from 2^SEQ_W-1 to 0.
- R10: While waiting for an answer, changes to the abandon and done inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | NPROC | Processor i holds a block |
| blk_id | input | NPROC*SEQ_W | Sequence numbers, processor i in bits [i*SEQ_W +: SEQ_W] |
| blk_done | input | NPROC | Block of processor i has finished executing |
| blk_abandon | input | NPROC | Block of processor i is on an untaken branch |
| cmt_ack | input | NPROC | Processor i finished its commit write-back |
| cmt_retry | input | NPROC | Processor i must re-execute instead of committing |
| grant | output | NPROC | One-hot commit grant pulse |
| head | output | SEQ_W | Sequence number of the next block allowed to commit |

## Verification
The bench builds the sequencer with four processors and a 4-bit sequence counter. The narrow counter lets a run of abandoned blocks carry the head across the wrap from 15 to 0 within a few cycles. Four processors are enough for two of them to present the same head id, which exercises the lowest-index choice. They also allow stray answers from processors that hold no grant.

// File: rtl/commit_sequencer.sv
module commit_sequencer #(
  parameter int NPROC = 4,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPROC-1:0]       blk_valid,
  input  logic [NPROC*SEQ_W-1:0] blk_id,
  input  logic [NPROC-1:0]       blk_done,
  input  logic [NPROC-1:0]       blk_abandon,
  input  logic [NPROC-1:0]       cmt_ack,
  input  logic [NPROC-1:0]       cmt_retry,
  output logic [NPROC-1:0]       grant,
  output logic [SEQ_W-1:0]       head
);
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic [SEQ_W-1:0] head_q;
  logic             wait_q;
  logic [IW-1:0]    owner_q;
  logic [NPROC-1:0] grant_q;
  logic [NPROC-1:0] hit;
  logic [IW-1:0]    sel;
  logic             found;

  for (genvar g = 0; g < NPROC; g++) begin : g_match
    assign hit[g] = blk_valid[g] && (blk_id[g*SEQ_W +: SEQ_W] == head_q);
  end

  always_comb begin
    sel = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  assign found = |hit;

  wire own_ack   = cmt_ack[owner_q];
  wire own_retry = cmt_retry[owner_q];
  wire [NPROC-1:0] sel_bit = NPROC'(1) << sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      wait_q  <= 1'b0;
      owner_q <= '0;
      grant_q <= '0;
    end else begin
      grant_q <= '0;
      if (wait_q) begin
        if (own_ack) begin
          head_q <= head_q + 1'b1;
          wait_q <= 1'b0;
        end else if (own_retry) begin
          wait_q <= 1'b0;
        end
      end else if (found) begin
        if (blk_abandon[sel]) begin
          head_q <= head_q + 1'b1;
        end else if (blk_done[sel]) begin
          grant_q <= sel_bit;
          owner_q <= sel;
          wait_q  <= 1'b1;
        end
      end
    end
  end

  assign grant = grant_q;
  assign head  = head_q;
endmodule

// File: rtl/commit_sequencer_chk.sv
module commit_sequencer_chk #(
  parameter int NPROC = 4,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] blk_valid,
  input logic [NPROC-1:0] blk_done,
  input logic [NPROC-1:0] grant,
  input logic [SEQ_W-1:0] head
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (grant == '0 && head == '0));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (grant == '0));

  a_r2_grant_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> $past(|(blk_valid & blk_done)));

  a_r9_head_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (head != $past(head)) |-> (head == SEQ_W'($past(head) + 1'b1)));

  a_r4_head_holds_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> $stable(head));
endmodule

bind commit_sequencer commit_sequencer_chk #(.NPROC(NPROC), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_done(blk_done),
  .grant(grant), .head(head)
);

// File: tb/commit_sequencer_tb.sv
module commit_sequencer_tb;
  localparam int CLK_T = 10;
  localparam int NP = 4;
  localparam int SW = 4;
  localparam int NV = 19;

  // {valid, ids(p3..p0), done, abandon, ack, retry, exp_grant, exp_head}
  localparam logic [43:0] VEC [NV] = '{
    {4'b0000, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'h0},
    {4'b0100, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'h0},
    {4'b0100, 16'h0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'h0},
    {4'b0100, 16'h0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'h0},
    {4'b0100, 16'h0000, 4'b0100, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'h0},
    {4'b0100, 16'h0000, 4'b0100, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'h1},
    {4'b0001, 16'h0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'h1},
    {4'b0001, 16'h0001, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'h2},
    {4'b1010, 16'h2020, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'h2},
    {4'b1010, 16'h2020, 4'b1010, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'h2},
    {4'b1010, 16'h2020, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'h2},
    {4'b1010, 16'h2020, 4'b1010, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'h3},
    {4'b1000, 16'h3000, 4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'h4},
    {4'b1001, 16'h4005, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'h5},
    {4'b0001, 16'h0005, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'h5},
    {4'b0011, 16'h0065, 4'b0011, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'h6},
    {4'b0010, 16'h0060, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'h6},
    {4'b0010, 16'h0060, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'h6},
    {4'b0010, 16'h0060, 4'b0010, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'h7}
  };

  localparam string VTAG [NV] = '{
    "R8", "R8", "R2", "R2", "R4", "R5", "R2", "R5", "R3", "R6",
    "R6", "R6", "R7", "R7", "R2", "R5", "R5", "R10", "R4"
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] blk_valid = '0, blk_done = '0, blk_abandon = '0;
  logic [NP-1:0] cmt_ack = '0, cmt_retry = '0;
  logic [NP*SW-1:0] blk_id = '0;
  logic [NP-1:0] grant;
  logic [SW-1:0] head;
  int total = 0;
  int bad = 0;

  always #(CLK_T/2) clk = ~clk;

  commit_sequencer #(.NPROC(NP), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_id(blk_id),
    .blk_done(blk_done), .blk_abandon(blk_abandon), .cmt_ack(cmt_ack),
    .cmt_retry(cmt_retry), .grant(grant), .head(head)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    check({4'b0, grant}, 8'h0, "R1 grant in reset");
    check({4'b0, head}, 8'h0, "R1 head in reset");
    rst_n = 1'b1;
    step();
    check({4'b0, grant}, 8'h0, "R1 grant after reset");
    check({4'b0, head}, 8'h0, "R1 head after reset");

    for (int v = 0; v < NV; v++) begin
      {blk_valid, blk_id, blk_done, blk_abandon, cmt_ack, cmt_retry} = VEC[v][43:8];
      step();
      check({4'b0, grant}, {4'b0, VEC[v][7:4]}, $sformatf("%s vec %0d grant", VTAG[v], v));
      check({4'b0, head}, {4'b0, VEC[v][3:0]}, $sformatf("%s vec %0d head", VTAG[v], v));
    end

    // R9: retire abandoned blocks until the head wraps
    cmt_ack = '0;
    cmt_retry = '0;
    blk_done = '0;
    blk_valid = 4'b0001;
    blk_abandon = 4'b0001;
    for (int k = 7; k < 16; k++) begin
      blk_id = 16'(k);
      step();
      check({4'b0, head}, 8'((k + 1) % 16), "R9 wrap skip head");
      check({4'b0, grant}, 8'h0, "R7 no grant on abandon");
    end

    // R1: reset in the middle of a run
    blk_abandon = '0;
    blk_id = 16'h0001;
    blk_done = 4'b0001;
    step();
    check({4'b0, head}, 8'h0, "R8 head holds");
    blk_id = 16'h0000;
    rst_n = 1'b0;
    step();
    check({4'b0, grant}, 8'h0, "R1 grant mid reset");
    check({4'b0, head}, 8'h0, "R1 head mid reset");
    rst_n = 1'b1;
    step();
    check({4'b0, grant}, 8'h1, "R2 grant after reset release");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule